// File: doc/BRIEF.md
# Global checkpoint sequencing controller

This controller sits in each node of a shared-memory multiprocessor and decides when the node takes a checkpoint, when an older checkpoint becomes trusted, and what to roll back to when a fault is reported. Time is measured on a logical clock that advances only when a coherence request is processed. After a fixed number of such requests a new checkpoint opens, and the architectural register file is copied into a shadow slot that carries the new checkpoint number.

A finished checkpoint waits until every coherence request issued in the interval before it has been answered. Validation runs in the background while execution goes on, and several checkpoints can wait at once. Each validation moves the recovery point forward by one number and frees the older shadow slot. A recovery request drops every in-flight transaction, rewinds the active number to the recovery point and presents that point's saved registers. An I/O gate tells whether data tagged with a given checkpoint number may leave the node. Checkpoint numbers wrap, and every comparison between them is taken as a distance from the recovery point.

Top module: `ckpt_seq`

## Requirements
- R1: After reset the active number and the recovery number are both 0, the pending count is 0, createStall and restoreValid are 0, and restoreRegs is all zeros.
- R2: coherReq advances the logical clock by one, up to K. Idle cycles do not advance it. Once the clock holds K, with room for another checkpoint and no recovery, activeCn increases by one at the next rising edge and the clock returns to 0. A request that arrives in that same cycle belongs to the interval that is closing.
- R3: When a checkpoint is created, the archRegs value present in that cycle is stored in the shadow slot of the new number. That value is what a later recovery presents once the number has become the recovery point.
- R4: If the pending count (activeCn minus recoveryCn, modulo 2^CN_W) is nonzero and the interval numbered recoveryCn has no outstanding requests, recoveryCn increases by one at the next edge. At most one checkpoint is validated per cycle.
- R5: The pending count never exceeds MAX_PEND. createStall is high exactly when the logical clock holds K and the pending count equals MAX_PEND. While it is high no checkpoint is created.
- R6: A recoverReq sampled at an edge makes restoreValid high for exactly the following cycle, with restoreRegs equal to the shadow of recoveryCn. At the same edge activeCn becomes recoveryCn, and all outstanding counts and the logical clock are cleared. restoreRegs holds its value between recoveries.
- R7: Recovery takes priority: in a cycle with recoverReq, no checkpoint is created or validated, and that cycle's request and response are dropped.
- R8: ioCommit is combinational and is 1 exactly when ((ioTagCn - recoveryCn) mod 2^CN_W) is greater than the pending count, that is, when the tagged interval is older than the recovery point.
- R9: Checkpoint numbers wrap from 2^CN_W-1 to 0 on both activeCn and recoveryCn.
- R10: A request is counted against the interval shown on activeCn in its cycle. A response (coherResp with respCn) lowers the count of the interval respCn, which must lie within the live window from recoveryCn to activeCn and have a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coherReq | input | 1 | One coherence request processed this cycle |
| coherResp | input | 1 | One coherence request completed this cycle |
| respCn | input | CN_W | Interval number of the completed request |
| recoverReq | input | 1 | Fault reported; roll back to the recovery point |
| archRegs | input | NUM_REGS*REG_W | Current architectural register file |
| ioTagCn | input | CN_W | Interval number of the data queued for I/O |
| activeCn | output | CN_W | Number of the interval now executing |
| recoveryCn | output | CN_W | Number of the validated recovery point |
| pendingCnt | output | CN_W | Checkpoints awaiting validation |
| createStall | output | 1 | Boundary due but the pending limit has been reached |
| ioCommit | output | 1 | The tagged I/O data may leave the node |
| restoreValid | output | 1 | One-cycle pulse: restoreRegs holds the restore image |
| restoreRegs | output | NUM_REGS*REG_W | Saved register file of the recovery point |

## Verification
On every cycle, the in-RTL properties check several things. The pending count stays within its limit. A stalled boundary does not move the active number. The active number only ever steps by one after a full logical interval. The recovery point advances only out of a drained interval. A recovery leaves nothing pending. A capture lands in the slot it was aimed at. Responses are also checked to stay inside the live window. The questions of which saved image a recovery presents after captures, validations and wraps have interleaved, and whether the I/O gate agrees with the window, are answered only by the bench's long traffic runs. It compares every output each cycle against an arithmetic model.

// File: rtl/ckpt_seq_pkg.sv
package ckpt_seq_pkg;
  // strobes from the sequencing control to the shadow datapath
  typedef struct packed {
    logic capture;   // copy the register file into the slot of the new checkpoint
    logic restore;   // present the recovery-point slot on the restore port
  } shadowCtl_t;
endpackage

// File: rtl/ckpt_seq_ctrl.sv
module ckpt_seq_ctrl
  import ckpt_seq_pkg::*;
#(
  parameter int CN_W     = 3,
  parameter int SLOT_W   = 2,
  parameter int MAX_PEND = 2,
  parameter int K        = 3,
  parameter int OUT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coherReq,
  input  logic              coherResp,
  input  logic [CN_W-1:0]   respCn,
  input  logic              recoverReq,
  input  logic [CN_W-1:0]   ioTagCn,
  output logic [CN_W-1:0]   activeCn,
  output logic [CN_W-1:0]   recoveryCn,
  output logic [CN_W-1:0]   pendingCnt,
  output logic              createStall,
  output logic              ioCommit,
  output shadowCtl_t        ctl,
  output logic [SLOT_W-1:0] capSlot,
  output logic [SLOT_W-1:0] restSlot
);
  localparam int NSLOT  = 2 ** SLOT_W;
  localparam int LCLK_W = $clog2(K + 1);
  localparam logic [LCLK_W-1:0] LCLK_END = LCLK_W'(K);
  localparam logic [CN_W-1:0]   PEND_MAX = CN_W'(MAX_PEND);

  logic [LCLK_W-1:0] lclk;
  logic [OUT_W-1:0]  outst [NSLOT];
  logic [SLOT_W-1:0] actSlot, rpSlot, respSlot;
  logic [CN_W-1:0]   pend, ioOff;
  logic boundaryDue, windowFull, doCreate, doValidate, oldestIdle;

  assign actSlot  = activeCn[SLOT_W-1:0];
  assign rpSlot   = recoveryCn[SLOT_W-1:0];
  assign respSlot = respCn[SLOT_W-1:0];

  assign pend        = activeCn - recoveryCn;
  assign windowFull  = (pend == PEND_MAX);
  assign boundaryDue = (lclk == LCLK_END);
  assign oldestIdle  = (outst[rpSlot] == '0);
  assign doCreate    = !recoverReq && boundaryDue && !windowFull;
  assign doValidate  = !recoverReq && (pend != '0) && oldestIdle;

  assign pendingCnt  = pend;
  assign createStall = boundaryDue && windowFull;
  assign ioOff       = ioTagCn - recoveryCn;
  assign ioCommit    = (ioOff > pend);

  assign ctl.capture = doCreate;
  assign ctl.restore = recoverReq;
  assign capSlot     = SLOT_W'(actSlot + 1'b1);
  assign restSlot    = rpSlot;

  // logical clock: counts processed requests, saturates at the boundary
  always_ff @(posedge clk) begin
    if (!rst_n)                  lclk <= '0;
    else if (recoverReq || doCreate) lclk <= '0;
    else if (coherReq && !boundaryDue) lclk <= lclk + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeCn   <= '0;
      recoveryCn <= '0;
    end else if (recoverReq) begin
      activeCn   <= recoveryCn;
    end else begin
      if (doCreate)   activeCn   <= activeCn + 1'b1;
      if (doValidate) recoveryCn <= recoveryCn + 1'b1;
    end
  end

  // outstanding request count per live interval
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [OUT_W-1:0] cnt;
    logic inc, dec;
    assign inc = coherReq  && (actSlot  == SLOT_W'(s));
    assign dec = coherResp && (respSlot == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n || recoverReq) cnt <= '0;
      else                      cnt <= cnt + OUT_W'(inc) - OUT_W'(dec);
    end
    assign outst[s] = cnt;
  end

  // R5: window never grows past its limit
  p_pend_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PEND_MAX);
  // R5: a stalled boundary leaves the active number alone
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (createStall && !recoverReq) |=> (activeCn == $past(activeCn)));
  // R2: the active number steps by one, and only after a full interval
  p_create_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((activeCn != $past(activeCn)) && !$past(recoverReq)) |->
      ((activeCn == CN_W'($past(activeCn) + 1'b1)) && ($past(lclk) == LCLK_END)));
  // R4: the recovery point moves only out of a drained interval
  p_validate_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (recoveryCn != $past(recoveryCn)) |-> $past(oldestIdle));
  // R6: after a recovery nothing is pending
  p_recover_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recoverReq |=> (pendingCnt == '0));
  // R10: a response names a live interval that still has requests in flight
  p_resp_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    coherResp |-> ((outst[respSlot] != '0) && (CN_W'(respCn - recoveryCn) <= pend)));
endmodule

// File: rtl/ckpt_seq_shadow.sv
module ckpt_seq_shadow
  import ckpt_seq_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int FILE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shadowCtl_t        ctl,
  input  logic [SLOT_W-1:0] capSlot,
  input  logic [SLOT_W-1:0] restSlot,
  input  logic [FILE_W-1:0] archRegs,
  output logic              restoreValid,
  output logic [FILE_W-1:0] restoreRegs
);
  localparam int NSLOT = 2 ** SLOT_W;

  logic [FILE_W-1:0] shadow [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) shadow[i] <= '0;
    end else if (ctl.capture) begin
      shadow[capSlot] <= archRegs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restoreValid <= 1'b0;
      restoreRegs  <= '0;
    end else begin
      restoreValid <= ctl.restore;
      if (ctl.restore) restoreRegs <= shadow[restSlot];
    end
  end

  // R3: a capture lands in the slot of the new checkpoint
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> (shadow[$past(capSlot)] == $past(archRegs)));
endmodule

// File: rtl/ckpt_seq.sv
module ckpt_seq
  import ckpt_seq_pkg::*;
#(
  parameter int CN_W     = 3,
  parameter int SLOT_W   = 2,
  parameter int MAX_PEND = 2,
  parameter int K        = 3,
  parameter int OUT_W    = 3,
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      coherReq,
  input  logic                      coherResp,
  input  logic [CN_W-1:0]           respCn,
  input  logic                      recoverReq,
  input  logic [NUM_REGS*REG_W-1:0] archRegs,
  input  logic [CN_W-1:0]           ioTagCn,
  output logic [CN_W-1:0]           activeCn,
  output logic [CN_W-1:0]           recoveryCn,
  output logic [CN_W-1:0]           pendingCnt,
  output logic                      createStall,
  output logic                      ioCommit,
  output logic                      restoreValid,
  output logic [NUM_REGS*REG_W-1:0] restoreRegs
);
  localparam int FILE_W = NUM_REGS * REG_W;

  shadowCtl_t        ctl;
  logic [SLOT_W-1:0] capSlot, restSlot;

  ckpt_seq_ctrl #(
    .CN_W(CN_W), .SLOT_W(SLOT_W), .MAX_PEND(MAX_PEND), .K(K), .OUT_W(OUT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .coherReq(coherReq), .coherResp(coherResp),
    .respCn(respCn), .recoverReq(recoverReq), .ioTagCn(ioTagCn),
    .activeCn(activeCn), .recoveryCn(recoveryCn), .pendingCnt(pendingCnt),
    .createStall(createStall), .ioCommit(ioCommit), .ctl(ctl),
    .capSlot(capSlot), .restSlot(restSlot)
  );

  ckpt_seq_shadow #(
    .SLOT_W(SLOT_W), .FILE_W(FILE_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .capSlot(capSlot), .restSlot(restSlot),
    .archRegs(archRegs), .restoreValid(restoreValid), .restoreRegs(restoreRegs)
  );
endmodule

// File: tb/ckpt_seq_tb.sv
module ckpt_seq_tb;
  localparam int CN_W = 3, SLOT_W = 2, MAX_PEND = 2, K = 3, OUT_W = 3;
  localparam int NUM_REGS = 2, REG_W = 8, FW = NUM_REGS * REG_W;
  localparam int NCN = 2 ** CN_W, NS = 2 ** SLOT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coherReq = 0, coherResp = 0, recoverReq = 0;
  logic [CN_W-1:0] respCn = '0, ioTagCn = '0;
  logic [FW-1:0] archRegs = '0;
  logic [CN_W-1:0] activeCn, recoveryCn, pendingCnt;
  logic createStall, ioCommit, restoreValid;
  logic [FW-1:0] restoreRegs;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ckpt_seq #(.CN_W(CN_W), .SLOT_W(SLOT_W), .MAX_PEND(MAX_PEND), .K(K),
             .OUT_W(OUT_W), .NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .coherReq(coherReq), .coherResp(coherResp),
    .respCn(respCn), .recoverReq(recoverReq), .archRegs(archRegs),
    .ioTagCn(ioTagCn), .activeCn(activeCn), .recoveryCn(recoveryCn),
    .pendingCnt(pendingCnt), .createStall(createStall), .ioCommit(ioCommit),
    .restoreValid(restoreValid), .restoreRegs(restoreRegs));

  // arithmetic model of the requirements
  int mA, mR, mL, mRv;
  int mOut [NS];
  int mSh [NS];
  int mRestore;

  function automatic int pendOf(); return (mA - mR + NCN) % NCN; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mA <= 0; mR <= 0; mL <= 0; mRv <= 0; mRestore <= 0;
      for (int i = 0; i < NS; i++) begin mOut[i] <= 0; mSh[i] <= 0; end
    end else begin : upd
      int p;
      bit cr, va;
      p  = pendOf();
      cr = !recoverReq && (mL == K) && (p != MAX_PEND);
      va = !recoverReq && (p != 0) && (mOut[mR % NS] == 0);
      mRv <= recoverReq;
      if (recoverReq) begin
        mRestore <= mSh[mR % NS];
        mA <= mR; mL <= 0;
        for (int i = 0; i < NS; i++) mOut[i] <= 0;
      end else begin
        if (cr) begin
          mA <= (mA + 1) % NCN; mL <= 0;
          mSh[(mA + 1) % NS] <= int'(archRegs);
        end else if (coherReq && mL < K) mL <= mL + 1;
        if (va) mR <= (mR + 1) % NCN;
        for (int i = 0; i < NS; i++)
          mOut[i] <= mOut[i] + ((coherReq && (mA % NS) == i) ? 1 : 0)
                             - ((coherResp && (int'(respCn) % NS) == i) ? 1 : 0);
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpAll();
    int off;
    off = (int'(ioTagCn) - mR + NCN) % NCN;
    cmp("R2 R9 activeCn", int'(activeCn), mA);
    cmp("R4 R10 recoveryCn", int'(recoveryCn), mR);
    cmp("R5 pendingCnt", int'(pendingCnt), pendOf());
    cmp("R5 createStall", int'(createStall), int'((mL == K) && (pendOf() == MAX_PEND)));
    cmp("R8 ioCommit", int'(ioCommit), int'(off > pendOf()));
    cmp("R6 restoreValid", int'(restoreValid), mRv);
    cmp("R3 restoreRegs", int'(restoreRegs), mRestore);
  endtask

  // drive one cycle of stimulus at the falling edge, then compare
  task automatic step(input bit req, input bit respOk, input bit rec);
    int p, c;
    @(negedge clk);
    p = pendOf();
    c = (mR + int'($urandom % (p + 1))) % NCN;
    coherReq   = req && (mOut[mA % NS] < 6);
    coherResp  = respOk && (mOut[c % NS] > 0);
    respCn     = CN_W'(c);
    recoverReq = rec;
    archRegs   = FW'($urandom);
    ioTagCn    = CN_W'($urandom);
    #1 cmpAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    cmp("R1 activeCn", int'(activeCn), 0);
    cmp("R1 recoveryCn", int'(recoveryCn), 0);
    cmp("R1 pendingCnt", int'(pendingCnt), 0);
    cmp("R1 createStall", int'(createStall), 0);
    cmp("R1 restoreValid", int'(restoreValid), 0);
    cmp("R1 restoreRegs", int'(restoreRegs), 0);

    // requests only: fill the window until creation stalls (R5)
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0);
    cmp("R5 stalled at limit", int'(pendingCnt), MAX_PEND);
    // drain: validations cascade one per cycle (R4)
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b0);

    // R7: recovery in a cycle where a boundary is due with room
    for (int i = 0; i < 30 && !((mL == K) && (pendOf() < MAX_PEND)); i++)
      step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    cmp("R7 no create on recovery", int'(activeCn), int'(recoveryCn));
    cmp("R7 pulse", int'(restoreValid), 1);

    // mixed traffic sweeps with varying request/response/recovery density
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        bit rq, rs, rc;
        rq = ($urandom % 4) < (ph + 1);
        rs = ($urandom % 4) < (4 - ph);
        rc = ($urandom % (ph == 3 ? 16 : 96)) == 0;
        step(rq, rs, rc);
      end
    end
    step(1'b0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule